// File: doc/BRIEF.md
# Multi-Slot Micro-Op Queue

This block buffers decoded instructions between a decoder and an out-of-order dispatch stage. Each instruction brings a micro-op count, and the queue charges it that many slots from a shared pool of `SLOTS` slots. The count is clamped to the pool size, and a count of zero still costs one slot. Each cycle, up to `LANES` instructions are offered in parallel, with lane 0 the oldest. The queue accepts an in-order prefix of them, limited by the free slots and by an optional cap on writes per cycle.

Stored instructions leave one per cycle, oldest first, through a valid/ready output port. The `ZERO_LAT` parameter selects the output timing. When it is set, an instruction offered to an empty queue is visible on the output in the same cycle and can leave at once. When it is clear, every instruction waits one clock edge before it is visible. Slots are returned to the pool at the clock edge that ends the cycle in which their instruction leaves. The `busy` output shows that at least one slot is held.

Top module: `uop_queue`

## Requirements
- R1: After synchronous reset the queue holds nothing: `busy` is 0, `out_valid` is 0, and all `SLOTS` slots are free.
- R2: An accepted instruction holds `min(uops, SLOTS)` slots, and a `uops` value of 0 holds 1 slot. For example, `uops`=15 with `SLOTS`=8 is accepted into an empty queue and fills it.
- R3: A lane is refused when its slot need exceeds the slots that were free at the start of the cycle, minus the slots taken by lower accepted lanes in the same cycle.
- R4: Lanes are taken in order from lane 0 upward. A valid lane that is refused causes every higher lane to be refused in the same cycle. An invalid lane is skipped. `in_accept[i]` is high only when `in_valid[i]` is high.
- R5: With `MAX_IPC` nonzero, at most `MAX_IPC` lanes are accepted per cycle. This count starts again from zero every cycle. With `MAX_IPC`=0 there is no cap.
- R6: Instructions appear on `out_tag` in acceptance order, where lane 0 comes before lane 1 within a cycle.
- R7: While `out_valid` is 1 and `out_ready` is 0, the same instruction stays on the output in the next cycle, and younger entries wait behind it.
- R8: With `ZERO_LAT`=1, an instruction offered to an empty queue is on `out_tag` with `out_valid` in the same cycle. If `out_ready` is 1 it leaves in that cycle without occupying the queue. With `ZERO_LAT`=0, `out_valid` is 0 whenever the queue is empty, and an instruction first shows one cycle after acceptance.
- R9: `busy` is 1 exactly when at least one slot is occupied at the start of the cycle.
- R10: The slots of an instruction that leaves are returned at the clock edge that ends that cycle. A refusal caused by a full queue in the cycle of a departure becomes an acceptance in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | LANES | An instruction is offered on lane i |
| in_tag | input | LANES*TAG_W | Instruction tag per lane, lane i at bits [i*TAG_W +: TAG_W] |
| in_uops | input | LANES*UOP_W | Micro-op count per lane, lane i at bits [i*UOP_W +: UOP_W] |
| in_accept | output | LANES | Lane i is taken this cycle |
| out_valid | output | 1 | An instruction is on `out_tag` |
| out_tag | output | TAG_W | Tag of the oldest instruction |
| out_ready | input | 1 | Downstream takes the output this cycle |
| busy | output | 1 | At least one slot is occupied |

## Verification
`in_accept` is combinational on the offered lanes and on the free-slot count stored at the last edge, so it is checked in the same cycle as its stimulus. `out_valid` and `out_tag` are due in that same cycle in zero-latency mode and one edge later in delayed mode. Two instances with the two modes share one stimulus, which shows this one-cycle difference directly. `busy` and the effect of returned slots are due one edge after a departure. The bench drives at the falling edge, samples 1 ns later, and compares each result against the cycle in which it is due, never against the next one.

// File: rtl/uop_queue.sv
module uop_queue #(
  parameter int SLOTS    = 8,
  parameter int LANES    = 2,
  parameter int MAX_IPC  = 0,
  parameter bit ZERO_LAT = 1'b1,
  parameter int TAG_W    = 8,
  parameter int UOP_W    = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES-1:0]       in_valid,
  input  logic [LANES*TAG_W-1:0] in_tag,
  input  logic [LANES*UOP_W-1:0] in_uops,
  output logic [LANES-1:0]       in_accept,
  output logic                   out_valid,
  output logic [TAG_W-1:0]       out_tag,
  input  logic                   out_ready,
  output logic                   busy
);
  localparam int CW = $clog2(SLOTS + 1);
  localparam int PW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [TAG_W-1:0] tag_mem  [SLOTS];
  logic [CW-1:0]    size_mem [SLOTS];
  logic [PW-1:0]    rp, wp;
  logic [CW-1:0]    cnt, free;

  int            need [LANES];
  logic [PW-1:0] widx [LANES];
  logic [LANES-1:0] acc, wen;
  int used, fa, nwr, free_n, cnt_n;
  logic byp, pop_q, pop_b;

  function automatic int slots_of(input logic [UOP_W-1:0] u);
    int v;
    v = int'(u);
    if (v == 0) return 1;
    if (v > SLOTS) return SLOTS;
    return v;
  endfunction

  function automatic logic [PW-1:0] wrap(input int p);
    return PW'(p % SLOTS);
  endfunction

  always_comb begin
    int avail, taken;
    logic blocked;
    avail = int'(free);
    taken = 0;
    blocked = 1'b0;
    acc = '0;
    for (int i = 0; i < LANES; i++) begin
      need[i] = slots_of(in_uops[i*UOP_W +: UOP_W]);
      if (in_valid[i] && !blocked) begin
        if ((MAX_IPC == 0 || taken < MAX_IPC) && need[i] <= avail) begin
          acc[i] = 1'b1;
          avail -= need[i];
          taken++;
        end else begin
          blocked = 1'b1;
        end
      end
    end
    used = int'(free) - avail;
  end

  always_comb begin
    logic found;
    fa = 0;
    found = 1'b0;
    for (int i = 0; i < LANES; i++)
      if (acc[i] && !found) begin
        fa = i;
        found = 1'b1;
      end
  end

  assign in_accept = acc;
  assign byp       = ZERO_LAT && (cnt == '0) && (|acc);
  assign out_valid = (cnt != '0) || byp;
  assign out_tag   = (cnt != '0) ? tag_mem[rp] : in_tag[fa*TAG_W +: TAG_W];
  assign pop_q     = (cnt != '0) && out_ready;
  assign pop_b     = byp && out_ready;
  assign busy      = (free != CW'(SLOTS));

  always_comb begin
    int k;
    k = 0;
    for (int i = 0; i < LANES; i++) begin
      wen[i]  = acc[i] && !(pop_b && i == fa);
      widx[i] = wrap(int'(wp) + k);
      if (wen[i]) k++;
    end
    nwr    = k;
    free_n = int'(free) - used + (pop_q ? int'(size_mem[rp]) : 0) + (pop_b ? need[fa] : 0);
    cnt_n  = int'(cnt) + nwr - (pop_q ? 1 : 0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      free <= CW'(SLOTS);
      cnt  <= '0;
      rp   <= '0;
      wp   <= '0;
    end else begin
      free <= CW'(free_n);
      cnt  <= CW'(cnt_n);
      wp   <= wrap(int'(wp) + nwr);
      if (pop_q) rp <= wrap(int'(rp) + 1);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (wen[i]) begin
        tag_mem[widx[i]]  <= in_tag[i*TAG_W +: TAG_W];
        size_mem[widx[i]] <= CW'(need[i]);
      end
  end

  p_free_range_r3: assert property (@(posedge clk) disable iff (rst)
    int'(free) <= SLOTS);

  p_busy_matches_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) == (free == CW'(SLOTS)));

  p_accept_needs_valid_r4: assert property (@(posedge clk) disable iff (rst)
    (in_accept & ~in_valid) == '0);

  p_head_hold_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && out_tag == $past(out_tag));

  generate
    if (MAX_IPC != 0) begin : g_cap
      p_write_cap_r5: assert property (@(posedge clk) disable iff (rst)
        $countones(in_accept) <= MAX_IPC);
    end
    if (!ZERO_LAT) begin : g_dly
      p_empty_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0) |-> !out_valid);
    end
  endgenerate
endmodule

// File: tb/uop_queue_tb.sv
`timescale 1ns/1ps
module uop_queue_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]  in_valid = '0;
  logic [15:0] in_tag = '0;
  logic [7:0]  in_uops = '0;
  logic        out_ready = 1'b0;

  logic [1:0] acc_i, acc_d, acc_c;
  logic       ov_i, ov_d, ov_c, busy_i, busy_d, busy_c;
  logic [7:0] ot_i, ot_d, ot_c;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  uop_queue #(.SLOTS(8), .LANES(2), .MAX_IPC(0), .ZERO_LAT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_tag(in_tag), .in_uops(in_uops),
    .in_accept(acc_i), .out_valid(ov_i), .out_tag(ot_i), .out_ready(out_ready), .busy(busy_i));

  uop_queue #(.SLOTS(8), .LANES(2), .MAX_IPC(0), .ZERO_LAT(1'b0)) dut_d (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_tag(in_tag), .in_uops(in_uops),
    .in_accept(acc_d), .out_valid(ov_d), .out_tag(ot_d), .out_ready(out_ready), .busy(busy_d));

  uop_queue #(.SLOTS(8), .LANES(2), .MAX_IPC(1), .ZERO_LAT(1'b1)) dut_c (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_tag(in_tag), .in_uops(in_uops),
    .in_accept(acc_c), .out_valid(ov_c), .out_tag(ot_c), .out_ready(out_ready), .busy(busy_c));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [1:0] v, input logic [7:0] t0, input logic [3:0] u0,
                     input logic [7:0] t1, input logic [3:0] u1, input logic rdy);
    @(negedge clk);
    in_valid  = v;
    in_tag    = {t1, t0};
    in_uops   = {u1, u0};
    out_ready = rdy;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = '0;
    out_ready = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "busy_i", busy_i, 0);
    chk("R1", "ov_i", ov_i, 0);
    chk("R1", "busy_d", busy_d, 0);
    chk("R1", "ov_d", ov_d, 0);
  endtask

  task automatic t_latency();
    do_reset();
    cyc(2'b01, 8'h11, 4'd2, 8'h00, 4'd0, 1'b1);
    chk("R8", "acc_i", acc_i, 1);
    chk("R8", "ov_i same cycle", ov_i, 1);
    chk("R8", "ot_i same cycle", ot_i, 8'h11);
    chk("R8", "acc_d", acc_d, 1);
    chk("R8", "ov_d same cycle", ov_d, 0);
    chk("R9", "busy_i start", busy_i, 0);
    cyc(2'b00, 8'h00, 4'd0, 8'h00, 4'd0, 1'b1);
    chk("R8", "ov_i after bypass", ov_i, 0);
    chk("R9", "busy_i after bypass", busy_i, 0);
    chk("R8", "ov_d next cycle", ov_d, 1);
    chk("R8", "ot_d next cycle", ot_d, 8'h11);
    chk("R9", "busy_d held", busy_d, 1);
    cyc(2'b00, 8'h00, 4'd0, 8'h00, 4'd0, 1'b1);
    chk("R10", "busy_d freed", busy_d, 0);
    chk("R8", "ov_d drained", ov_d, 0);
  endtask

  task automatic t_order();
    do_reset();
    cyc(2'b11, 8'hA1, 4'd0, 8'hB2, 4'd3, 1'b0);
    chk("R2", "acc_i zero-count and 3", acc_i, 3);
    chk("R2", "acc_d", acc_d, 3);
    chk("R8", "ot_i shown", ot_i, 8'hA1);
    chk("R8", "ov_d empty", ov_d, 0);
    cyc(2'b11, 8'hC3, 4'd15, 8'hD4, 4'd1, 1'b0);
    chk("R3", "clamped 8 over 4 free", acc_i[0], 0);
    chk("R4", "higher lane blocked", acc_i[1], 0);
    chk("R7", "head held i", ot_i, 8'hA1);
    chk("R7", "head held d", ot_d, 8'hA1);
    chk("R9", "busy_i", busy_i, 1);
    cyc(2'b11, 8'hD4, 4'd4, 8'hE5, 4'd0, 1'b0);
    chk("R3", "in-cycle reduction", acc_i, 1);
    chk("R3", "in-cycle reduction d", acc_d, 1);
    cyc(2'b01, 8'hF6, 4'd0, 8'h00, 4'd0, 1'b1);
    chk("R10", "full refusal at departure", acc_i, 0);
    chk("R6", "first out", ot_i, 8'hA1);
    cyc(2'b01, 8'hF6, 4'd0, 8'h00, 4'd0, 1'b1);
    chk("R10", "accepted after return", acc_i, 1);
    chk("R6", "second out", ot_i, 8'hB2);
    chk("R6", "second out d", ot_d, 8'hB2);
    cyc(2'b00, 8'h00, 4'd0, 8'h00, 4'd0, 1'b1);
    chk("R6", "third out", ot_i, 8'hD4);
    cyc(2'b00, 8'h00, 4'd0, 8'h00, 4'd0, 1'b1);
    chk("R6", "fourth out", ot_i, 8'hF6);
    chk("R6", "fourth out d", ot_d, 8'hF6);
    cyc(2'b00, 8'h00, 4'd0, 8'h00, 4'd0, 1'b1);
    chk("R9", "busy_i drained", busy_i, 0);
    chk("R6", "ov_i drained", ov_i, 0);
  endtask

  task automatic t_clamp();
    do_reset();
    cyc(2'b01, 8'h77, 4'd15, 8'h00, 4'd0, 1'b0);
    chk("R2", "15 clamped accepted", acc_i, 1);
    cyc(2'b01, 8'h78, 4'd0, 8'h00, 4'd0, 1'b0);
    chk("R2", "full after clamp", acc_i, 0);
    chk("R2", "full after clamp d", acc_d, 0);
    cyc(2'b00, 8'h00, 4'd0, 8'h00, 4'd0, 1'b1);
    chk("R6", "clamped head", ot_i, 8'h77);
    cyc(2'b00, 8'h00, 4'd0, 8'h00, 4'd0, 1'b0);
    chk("R10", "all slots back", busy_i, 0);
  endtask

  task automatic t_cap();
    do_reset();
    cyc(2'b11, 8'h21, 4'd1, 8'h22, 4'd1, 1'b0);
    chk("R5", "cap one lane", acc_c, 1);
    chk("R5", "no cap both lanes", acc_i, 3);
    cyc(2'b11, 8'h23, 4'd1, 8'h24, 4'd1, 1'b0);
    chk("R5", "cap counter restarts", acc_c, 1);
    cyc(2'b10, 8'h00, 4'd0, 8'h25, 4'd1, 1'b0);
    chk("R4", "invalid lane skipped", acc_c, 2);
    chk("R6", "cap head", ot_c, 8'h21);
    cyc(2'b00, 8'h00, 4'd0, 8'h00, 4'd0, 1'b1);
    cyc(2'b00, 8'h00, 4'd0, 8'h00, 4'd0, 1'b1);
    chk("R6", "cap second", ot_c, 8'h23);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_order();
    t_clamp();
    t_cap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule